// File: doc/BRIEF.md
# Serial Control Register Interface for an Integer-N Synthesizer

This block is the programming port of an integer-N frequency synthesizer. A host moves 21-bit words in over three wires: a shift clock, a data line and a load strobe. Each word is 19 data bits followed by a 2-bit address. The rising edge of the load strobe commits the word to one of four control words: reference divide, feedback divide, function and initialization. The stored words are split into the fields that the divider, charge-pump, lock-detect and fast-lock logic need.

The block also works out control state that depends on the order of writes. An initialization write holds the counters in their load state and tri-states the charge pump until the next feedback-divide write releases them. Power-down is either immediate on commit or deferred to the next transition of the phase-detector-rate signal. Any change to the frequency setting raises a one-cycle pulse. A sticky flag records divide settings outside the legal range.

All three serial inputs, the power-down pin and the phase-detector-rate signal are taken as already synchronous to `clk`. Serial edges are found by comparing each input with its value on the previous clock.

Top module: `syn3w_regif`

## Requirements
- R1: Data is sampled on each rising edge of `ser_clk` and shifted most significant bit first. On a rising edge of `ser_le` the last 21 bits shifted in are decoded: bits [1:0] are the address and bits [20:2] are data D18..D0. Earlier extra bits have no effect.
- R2: Address 0 stores the reference divide value from D13..D0 to `ref_div` and the lock precision bit from D18 to `lock_prec`.
- R3: Address 1 stores the swallow count from D4..D0 to `swallow_cnt`, the program count from D17..D5 to `prog_cnt` and the pump gain bit from D18 to `cp_gain`.
- R4: Address 2 stores the function fields: counter reset D0 (`cnt_rst`), power select low D1 (`pd_sel_lo`), lock detect select D4..D2 (`lock_sel`), pump polarity D5 (`cp_pol`), pump off D6 (`cp_off`), fast enable D7 (`fast_en`), fast mode D9 (`fast_mode`), fast timer D13..D10 (`fast_tmr`) and power select high D17 (`pd_sel_hi`).
- R5: Address 3 updates the same fields as address 2. It also sets `cnt_hold` and `cp_tristate` until the next address 1 write clears `cnt_hold`.
- R6: `cp_tristate` is 1 whenever the pump off field is 1, even when there is no hold.
- R7: A function write with D1=1 and D17=0 drives `power_down` to 1 in the cycle the write commits. A function write with D1=0 returns it to 0.
- R8: A function write with D1=1 and D17=1 leaves `power_down` at 0 until `pfd_ref` next changes level. `power_down` is 1 one clock after that change is seen.
- R9: `pdn_n` low forces `power_down` to 1 whatever the stored bits are.
- R10: `freq_chg` is 1 for exactly one cycle after each address 0 or address 1 write, and it stays 0 for address 2 and address 3 writes.
- R11: A write with a reference divide of 0, or with a program count below 3, is still stored and sets `bad_setting`. The flag stays 1 until reset.
- R12: Shift clocks with `ser_le` held low change no output.
- R13: After reset all stored fields, `cnt_hold`, `cp_tristate`, `freq_chg`, `bad_setting` and the stored power-down state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (synchronous to clk) |
| ser_data | input | 1 | Serial data |
| ser_le | input | 1 | Load strobe, commits on rising edge |
| pdn_n | input | 1 | Power-down pin, active low |
| pfd_ref | input | 1 | Phase-detector-rate signal for deferred power-down |
| ref_div | output | 14 | Reference divide value |
| lock_prec | output | 1 | Lock detect precision select |
| swallow_cnt | output | 5 | Swallow counter value |
| prog_cnt | output | 13 | Program counter value |
| cp_gain | output | 1 | Charge pump high-current select |
| lock_sel | output | 3 | Lock detect output select |
| fast_en | output | 1 | Fast lock enable |
| fast_mode | output | 1 | Fast lock mode / general output value |
| fast_tmr | output | 4 | Fast lock timer code |
| pd_sel_lo | output | 1 | Power select low bit |
| pd_sel_hi | output | 1 | Power select high bit |
| cp_pol | output | 1 | Charge pump polarity |
| cp_off | output | 1 | Charge pump off field |
| cnt_rst | output | 1 | Counter reset field |
| cnt_hold | output | 1 | Counters held in load state |
| cp_tristate | output | 1 | Charge pump output tri-stated |
| power_down | output | 1 | Block powered down |
| freq_chg | output | 1 | One-cycle frequency-change pulse |
| bad_setting | output | 1 | Sticky illegal divide flag |

## Verification
The assertions watch properties that must hold on every cycle. The frequency-change pulse never lasts two cycles. The divide fields never move without that pulse. The hold state only drops together with that pulse. The illegal-setting flag never clears, and power-down never ends while the pin is low. Field positions, the release of the hold by a feedback-divide write, and the difference between immediate and deferred power-down depend on particular write sequences, so only the bench's scenarios can show them. The bench sweeps every lock-select and timer code and every swallow value and compares each against arithmetic expectations.

// File: rtl/syn3w_pkg.sv
package syn3w_pkg;
   localparam int ADDR_W_DEF = 2;
   localparam int DATA_W_DEF = 19;

   typedef enum logic [1:0] {
      SEL_REF  = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_FUNC = 2'd2,
      SEL_INIT = 2'd3
   } sel_e;

   // function word bit positions (decoded by neighbouring logic)
   localparam int FB_CRST  = 0;
   localparam int FB_PDLO  = 1;
   localparam int FB_LD    = 2;
   localparam int FB_POL   = 5;
   localparam int FB_OFF   = 6;
   localparam int FB_FEN   = 7;
   localparam int FB_FMODE = 9;
   localparam int FB_TMR   = 10;
   localparam int FB_PDHI  = 17;
endpackage

// File: rtl/syn3w_shift.sv
module syn3w_shift #(
   parameter int WORD_W    = 21,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              commit
);
   logic              sclk_q, le_q;
   logic [WORD_W-1:0] sh_q, sh_d;
   logic              sclk_rise;

   assign sclk_rise = ser_clk & ~sclk_q;
   assign commit    = ser_le & ~le_q;
   assign word      = sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_d = {sh_q[WORD_W-2:0], ser_data};
      end else begin : g_lsb
         assign sh_d = {ser_data, sh_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
         sh_q   <= '0;
      end else begin
         sclk_q <= ser_clk;
         le_q   <= ser_le;
         if (sclk_rise) sh_q <= sh_d;
      end
   end
endmodule

// File: rtl/syn3w_regs.sv
module syn3w_regs
   import syn3w_pkg::*;
#(
   parameter int DATA_W = 19,
   parameter int ADDR_W = 2,
   parameter int R_W    = 14,
   parameter int A_W    = 5,
   parameter int B_W    = 13,
   parameter int MIN_B  = 3,
   localparam int WORD_W = DATA_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] word,
   output logic [DATA_W-1:0] ref_q,
   output logic [DATA_W-1:0] div_q,
   output logic [DATA_W-1:0] func_q,
   output logic              hold_q,
   output logic              chg_q,
   output logic              bad_q,
   output logic              fn_wr
);
   logic [DATA_W-1:0] data;
   sel_e              sel;
   logic              wr_ref, wr_div, wr_init, bad_now;

   assign data    = word[WORD_W-1 -: DATA_W];
   assign sel     = sel_e'(word[1:0]);
   assign wr_ref  = commit && (sel == SEL_REF);
   assign wr_div  = commit && (sel == SEL_DIV);
   assign wr_init = commit && (sel == SEL_INIT);
   assign fn_wr   = commit && ((sel == SEL_FUNC) || (sel == SEL_INIT));
   assign bad_now = (wr_ref && (data[R_W-1:0] == '0)) ||
                    (wr_div && (data[A_W +: B_W] < B_W'(MIN_B)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         div_q  <= '0;
         func_q <= '0;
         hold_q <= 1'b0;
         chg_q  <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         chg_q <= wr_ref | wr_div;
         if (bad_now) bad_q <= 1'b1;
         if (wr_ref)  ref_q  <= data;
         if (wr_div)  div_q  <= data;
         if (fn_wr)   func_q <= data;
         if (wr_init)     hold_q <= 1'b1;
         else if (wr_div) hold_q <= 1'b0;
      end
   end
endmodule

// File: rtl/syn3w_pwr.sv
module syn3w_pwr (
   input  logic clk,
   input  logic rst_n,
   input  logic fn_wr,
   input  logic pd_lo_in,
   input  logic pd_hi_in,
   input  logic pdn_n,
   input  logic pfd_ref,
   output logic power_down
);
   logic pd_q, pend_q, pfd_q, pfd_tog;

   assign pfd_tog    = pfd_ref ^ pfd_q;
   assign power_down = ~pdn_n | pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q   <= 1'b0;
         pend_q <= 1'b0;
         pfd_q  <= 1'b0;
      end else begin
         pfd_q <= pfd_ref;
         if (fn_wr) begin
            if (!pd_lo_in) begin
               pd_q   <= 1'b0;
               pend_q <= 1'b0;
            end else if (!pd_hi_in) begin
               pd_q   <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               pd_q   <= 1'b0;
               pend_q <= 1'b1;
            end
         end else if (pend_q && pfd_tog) begin
            pd_q   <= 1'b1;
            pend_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/syn3w_regif.sv
module syn3w_regif
   import syn3w_pkg::*;
#(
   parameter int DATA_W    = DATA_W_DEF,
   parameter int ADDR_W    = ADDR_W_DEF,
   parameter int R_W       = 14,
   parameter int A_W       = 5,
   parameter int B_W       = 13,
   parameter int LD_W      = 3,
   parameter int TMR_W     = 4,
   parameter int MIN_B     = 3,
   parameter bit MSB_FIRST = 1'b1,
   localparam int WORD_W   = DATA_W + ADDR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             ser_le,
   input  logic             pdn_n,
   input  logic             pfd_ref,
   output logic [R_W-1:0]   ref_div,
   output logic             lock_prec,
   output logic [A_W-1:0]   swallow_cnt,
   output logic [B_W-1:0]   prog_cnt,
   output logic             cp_gain,
   output logic [LD_W-1:0]  lock_sel,
   output logic             fast_en,
   output logic             fast_mode,
   output logic [TMR_W-1:0] fast_tmr,
   output logic             pd_sel_lo,
   output logic             pd_sel_hi,
   output logic             cp_pol,
   output logic             cp_off,
   output logic             cnt_rst,
   output logic             cnt_hold,
   output logic             cp_tristate,
   output logic             power_down,
   output logic             freq_chg,
   output logic             bad_setting
);
   generate
      if (ADDR_W != 2) begin : g_bad_addr
         $error("syn3w_regif: four control words need a 2-bit address");
      end
      if (DATA_W < R_W + 1) begin : g_bad_ref
         $error("syn3w_regif: reference word too narrow");
      end
      if (DATA_W < A_W + B_W + 1) begin : g_bad_div
         $error("syn3w_regif: divide word too narrow");
      end
      if (DATA_W <= FB_PDHI || FB_TMR + TMR_W > FB_PDHI) begin : g_bad_fn
         $error("syn3w_regif: function word layout does not fit");
      end
      if (FB_LD + LD_W > FB_POL) begin : g_bad_ld
         $error("syn3w_regif: lock select overlaps polarity bit");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              commit, fn_wr, hold_q;
   logic [DATA_W-1:0] ref_q, div_q, func_q;

   syn3w_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .word(word), .commit(commit)
   );

   syn3w_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .R_W(R_W), .A_W(A_W),
                .B_W(B_W), .MIN_B(MIN_B)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
      .ref_q(ref_q), .div_q(div_q), .func_q(func_q), .hold_q(hold_q),
      .chg_q(freq_chg), .bad_q(bad_setting), .fn_wr(fn_wr)
   );

   syn3w_pwr u_pwr (
      .clk(clk), .rst_n(rst_n), .fn_wr(fn_wr),
      .pd_lo_in(word[ADDR_W + FB_PDLO]), .pd_hi_in(word[ADDR_W + FB_PDHI]),
      .pdn_n(pdn_n), .pfd_ref(pfd_ref), .power_down(power_down)
   );

   assign ref_div     = ref_q[R_W-1:0];
   assign lock_prec   = ref_q[DATA_W-1];
   assign swallow_cnt = div_q[A_W-1:0];
   assign prog_cnt    = div_q[A_W +: B_W];
   assign cp_gain     = div_q[DATA_W-1];
   assign cnt_rst     = func_q[FB_CRST];
   assign pd_sel_lo   = func_q[FB_PDLO];
   assign lock_sel    = func_q[FB_LD +: LD_W];
   assign cp_pol      = func_q[FB_POL];
   assign cp_off      = func_q[FB_OFF];
   assign fast_en     = func_q[FB_FEN];
   assign fast_mode   = func_q[FB_FMODE];
   assign fast_tmr    = func_q[FB_TMR +: TMR_W];
   assign pd_sel_hi   = func_q[FB_PDHI];
   assign cnt_hold    = hold_q;
   assign cp_tristate = hold_q | func_q[FB_OFF];
endmodule

// File: rtl/syn3w_chk.sv
module syn3w_chk #(
   parameter int R_W = 14,
   parameter int B_W = 13
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pdn_n,
   input logic           freq_chg,
   input logic           cnt_hold,
   input logic           bad_setting,
   input logic           power_down,
   input logic [R_W-1:0] ref_div,
   input logic [B_W-1:0] prog_cnt
);
   // R10
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_chg |=> !freq_chg);

   // R12
   div_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_chg |-> ($stable(ref_div) && $stable(prog_cnt)));

   // R5
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnt_hold) |-> freq_chg);

   // R11
   bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_setting |=> bad_setting);

   // R9
   pin_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_n && $past(!pdn_n)) |-> (power_down && $stable(power_down)));
endmodule

bind syn3w_regif syn3w_chk #(.R_W(R_W), .B_W(B_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .freq_chg(freq_chg),
   .cnt_hold(cnt_hold), .bad_setting(bad_setting), .power_down(power_down),
   .ref_div(ref_div), .prog_cnt(prog_cnt)
);

// File: tb/syn3w_regif_tb.sv
`timescale 1ns/1ps
module syn3w_regif_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic pdn_n = 1'b1, pfd_ref = 1'b0;
   logic [13:0] ref_div;
   logic        lock_prec, cp_gain, fast_en, fast_mode, pd_sel_lo, pd_sel_hi;
   logic        cp_pol, cp_off, cnt_rst, cnt_hold, cp_tristate, power_down;
   logic        freq_chg, bad_setting;
   logic [4:0]  swallow_cnt;
   logic [12:0] prog_cnt;
   logic [2:0]  lock_sel;
   logic [3:0]  fast_tmr;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   syn3w_regif u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .pdn_n(pdn_n), .pfd_ref(pfd_ref), .ref_div(ref_div),
      .lock_prec(lock_prec), .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt),
      .cp_gain(cp_gain), .lock_sel(lock_sel), .fast_en(fast_en),
      .fast_mode(fast_mode), .fast_tmr(fast_tmr), .pd_sel_lo(pd_sel_lo),
      .pd_sel_hi(pd_sel_hi), .cp_pol(cp_pol), .cp_off(cp_off),
      .cnt_rst(cnt_rst), .cnt_hold(cnt_hold), .cp_tristate(cp_tristate),
      .power_down(power_down), .freq_chg(freq_chg), .bad_setting(bad_setting)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [18:0] fn_word(input logic hi, input logic [3:0] tmr,
      input logic fm, input logic fe, input logic off, input logic pol,
      input logic [2:0] ld, input logic lo, input logic cr);
      return {1'b0, hi, 3'b000, tmr, fm, 1'b0, fe, off, pol, ld, lo, cr};
   endfunction

   task automatic shift_bit(input logic b);
      @(negedge clk); ser_data = b; ser_clk = 1'b0;
      @(negedge clk); ser_clk = 1'b1;
   endtask

   task automatic send(input logic [1:0] ad, input logic [18:0] d);
      logic [20:0] w;
      w = {d, ad};
      for (int i = 20; i >= 0; i--) shift_bit(w[i]);
      @(negedge clk); ser_clk = 1'b0; ser_le = 1'b1;
      @(negedge clk); ser_le = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      // R13 reset state
      chk("R13 ref_div", 32'(ref_div), 0);
      chk("R13 prog_cnt", 32'(prog_cnt), 0);
      chk("R13 hold", 32'(cnt_hold), 0);
      chk("R13 tristate", 32'(cp_tristate), 0);
      chk("R13 freq_chg", 32'(freq_chg), 0);
      chk("R13 bad", 32'(bad_setting), 0);
      chk("R13 power_down", 32'(power_down), 0);

      // R1 extra leading bits are pushed out; R2 reference word
      for (int k = 0; k < 5; k++) shift_bit(1'b1);
      send(2'd0, {1'b1, 4'b0000, 14'd10});
      chk("R2 ref_div", 32'(ref_div), 10);
      chk("R2 lock_prec", 32'(lock_prec), 1);
      chk("R10 pulse on ref write", 32'(freq_chg), 1);
      @(negedge clk);
      chk("R10 pulse ends", 32'(freq_chg), 0);
      send(2'd0, {1'b0, 4'b0000, 14'h3FFF});
      chk("R1 R2 max ref", 32'(ref_div), 32'h3FFF);
      chk("R2 lock_prec clear", 32'(lock_prec), 0);

      // R3 swallow sweep, program count = 3 + a
      for (int a = 0; a < 32; a++) begin
         send(2'd1, {1'(a & 1), 13'(3 + a), 5'(a)});
         chk("R3 swallow", 32'(swallow_cnt), 32'(a));
         chk("R3 prog", 32'(prog_cnt), 32'(3 + a));
         chk("R3 gain", 32'(cp_gain), 32'(a & 1));
      end
      send(2'd1, {1'b0, 13'd8191, 5'd31});
      chk("R3 prog max", 32'(prog_cnt), 8191);
      chk("R11 legal values no flag", 32'(bad_setting), 0);

      // R12 shift clocks without load strobe
      for (int k = 0; k < 21; k++) shift_bit(1'b0);
      @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      chk("R12 prog held", 32'(prog_cnt), 8191);
      chk("R12 ref held", 32'(ref_div), 32'h3FFF);

      // R4 sweep lock select and timer codes
      for (int ld = 0; ld < 8; ld++) begin
         for (int t = 0; t < 16; t++) begin
            send(2'd2, fn_word(1'b0, 4'(t), 1'(t >> 1), 1'(t), 1'b0, 1'(ld),
                               3'(ld), 1'b0, 1'(t >> 2)));
            chk("R4 lock_sel", 32'(lock_sel), 32'(ld));
            chk("R4 timer", 32'(fast_tmr), 32'(t));
            chk("R4 fast_en", 32'(fast_en), 32'(t & 1));
            chk("R4 fast_mode", 32'(fast_mode), 32'((t >> 1) & 1));
            chk("R4 cp_pol", 32'(cp_pol), 32'(ld & 1));
            chk("R4 cnt_rst", 32'(cnt_rst), 32'((t >> 2) & 1));
            chk("R10 no pulse on function write", 32'(freq_chg), 0);
         end
      end
      chk("R4 pd_sel_lo", 32'(pd_sel_lo), 0);

      // R6 pump off field
      send(2'd2, fn_word(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0));
      chk("R6 cp_off", 32'(cp_off), 1);
      chk("R6 tristate from field", 32'(cp_tristate), 1);
      chk("R6 no hold", 32'(cnt_hold), 0);

      // R5 initialization write then release
      send(2'd3, fn_word(1'b0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0));
      chk("R5 hold set", 32'(cnt_hold), 1);
      chk("R5 tristate", 32'(cp_tristate), 1);
      chk("R5 timer mirrors", 32'(fast_tmr), 9);
      chk("R5 lock_sel mirrors", 32'(lock_sel), 5);
      chk("R10 no pulse on init write", 32'(freq_chg), 0);
      send(2'd0, {1'b0, 4'b0000, 14'd7});
      chk("R5 ref write keeps hold", 32'(cnt_hold), 1);
      send(2'd1, {1'b1, 13'd93, 5'd24});
      chk("R5 hold released", 32'(cnt_hold), 0);
      chk("R5 tristate released", 32'(cp_tristate), 0);
      chk("R3 div 93/24 b", 32'(prog_cnt), 93);

      // R7 immediate power-down
      send(2'd2, fn_word(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0));
      chk("R7 immediate down", 32'(power_down), 1);
      chk("R4 pd_sel_lo", 32'(pd_sel_lo), 1);
      send(2'd2, fn_word(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0));
      chk("R7 back to normal", 32'(power_down), 0);

      // R8 deferred power-down
      send(2'd2, fn_word(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0));
      chk("R8 not yet down", 32'(power_down), 0);
      chk("R4 pd_sel_hi", 32'(pd_sel_hi), 1);
      repeat (5) @(negedge clk);
      chk("R8 waits for edge", 32'(power_down), 0);
      pfd_ref = ~pfd_ref;
      @(negedge clk);
      chk("R8 down after edge", 32'(power_down), 1);
      send(2'd2, fn_word(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0));
      chk("R8 cleared", 32'(power_down), 0);

      // R9 pin forces power-down
      pdn_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 pin low", 32'(power_down), 1);
      pdn_n = 1'b1;
      @(negedge clk);
      chk("R9 pin high", 32'(power_down), 0);

      // R11 illegal settings stored and flagged
      send(2'd0, {1'b0, 4'b0000, 14'd0});
      chk("R11 ref zero stored", 32'(ref_div), 0);
      chk("R11 flag on ref zero", 32'(bad_setting), 1);
      send(2'd0, {1'b0, 4'b0000, 14'd5});
      chk("R11 flag sticky", 32'(bad_setting), 1);
      do_reset();
      send(2'd1, {1'b0, 13'd3, 5'd0});
      chk("R11 b=3 legal", 32'(bad_setting), 0);
      send(2'd1, {1'b0, 13'd2, 5'd1});
      chk("R11 b=2 stored", 32'(prog_cnt), 2);
      chk("R11 flag on b=2", 32'(bad_setting), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule